// File: doc/BRIEF.md
# Flipped Lifting 9/7 Wavelet Pipe

This block computes the 9/7 biorthogonal wavelet on a row of samples with the flipped form of the lifting steps. Each step is rewritten so that its constant multiplies only one operand, and the other two operands are simply added. Every stage is then the same three-input cell: one constant multiplier, one adder for the pair, and one final adder. The pair sum is formed while the product is being computed, so the register-to-register path is one multiply followed by one add. The four cell constants are reciprocals of the lifting constants and of their products. The outputs are unscaled: the high-pass result is the second prediction divided by the product of the first three lifting constants, and the low-pass result is the second update divided by the product of all four.

A row unit holds `LANES` identical pipes side by side. Lane s takes samples 2s, 2s+1 and 2s+2 of a window of 2·LANES+1 samples, so neighbouring lanes share one sample. Lane s also takes the three partial results of lane s-1, and each partial is consumed at the pipeline stage where it is needed. The first lane takes its partials from ports, for example from a column-deep store of the previous window. The last lane drives its partials out for the next window. One window enters per cycle, and the low-pass and high-pass results of every lane leave together four cycles later.

Top module: `lift97_row`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid_o` is 0 and every data output is 0.
- R2: The flattened sample window of one cycle feeds every lane, with lane s taking x0 = sample 2s, x1 = sample 2s+1 and x2 = sample 2s+2. One cycle after an accepted window, lane s holds a = rnd(x1·K1) + x0 + x2. Here rnd(v·K) = floor((v·K + 2^(FRAC_W-1)) / 2^FRAC_W), and K1 = round(2^FRAC_W / α) with α = -1.586134342. The last lane's a is on `pa_o`.
- R3: Two cycles after the window, b = rnd(x0·K2) + pa + a is formed, where pa is the lane's first partial input and K2 = round(2^FRAC_W/(α·β)) with β = -0.052980118. Lane 0 reads pa from `pa_i` one cycle after the window. The last lane's b is on `pb_o`.
- R4: Three cycles after the window, c = rnd(pa·K3) + pb + b is formed, with K3 = round(2^FRAC_W/(β·γ)) and γ = 0.882911075. Lane 0 reads pb from `pb_i` two cycles after the window. The last lane's c is on `pg_o`.
- R5: Four cycles after an accepted window, `out_valid_o` is 1 and the lane-s slice of `hi_o` is c. The lane-s slice of `lo_o` is rnd(pb·K4) + pg + c, with K4 = round(2^FRAC_W/(γ·δ)) and δ = 0.443506852. Lane 0 reads pg from `pg_i` three cycles after the window. Lane s occupies bits [s·ACC_W +: ACC_W].
- R6: For lanes s ≥ 1, the partial inputs pa, pb and pg are lane s-1's a, b and c for the same window.
- R7: Windows of full-scale samples (all +32767, all -32768, or alternating), with partial inputs at ±(2^17-1), ±(2^20-1) and ±(2^22-1), produce exact results with no wrap in the ACC_W-bit datapath.
- R8: A stage whose window was not accepted keeps its previous results. Samples and partial inputs presented with no accepted window behind them have no effect on any output. `out_valid_o` is 0 four cycles after a cycle with `in_valid_i` low.
- R9: Windows accepted on consecutive cycles each produce their own correct results on consecutive cycles, one window per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Sample window present this cycle |
| samp_i | input | (2·LANES+1)·DATA_W | Signed samples, sample k at bits [k·DATA_W +: DATA_W] |
| pa_i | input | ACC_W | Lane-0 first partial, one cycle after its window |
| pb_i | input | ACC_W | Lane-0 second partial, two cycles after its window |
| pg_i | input | ACC_W | Lane-0 third partial, three cycles after its window |
| pa_o | output | ACC_W | Last lane's first partial (a) |
| pb_o | output | ACC_W | Last lane's second partial (b) |
| pg_o | output | ACC_W | Last lane's third partial (c) |
| lo_o | output | LANES·ACC_W | Unscaled low-pass results, one per lane |
| hi_o | output | LANES·ACC_W | Unscaled high-pass results, one per lane |
| out_valid_o | output | 1 | Results on lo_o and hi_o belong to an accepted window |

## Verification
A wrong stage register or coefficient shows up at the port of its own stage: a bad `a` is visible on `pa_o` one cycle after the window. The same error then spreads into `pb_o`, `pg_o` and the low-pass result over the next three cycles. A broken lane-to-lane link corrupts only the slices of later lanes, so every lane's slice is compared each cycle. A stage that loads during an idle cycle changes a held output at once, and this is caught by driving unrelated values whenever no window is behind a stage.

// File: rtl/lift97_pkg.sv
package lift97_pkg;

    localparam real LIFT_ALPHA = -1.586134342;
    localparam real LIFT_BETA  = -0.052980118;
    localparam real LIFT_GAMMA =  0.882911075;
    localparam real LIFT_DELTA =  0.443506852;

    typedef enum logic [1:0] {
        STEP_PRED1 = 2'd0,
        STEP_UPD1  = 2'd1,
        STEP_PRED2 = 2'd2,
        STEP_UPD2  = 2'd3
    } lift_step_e;

    function automatic int to_fixed(input real v, input int frac);
        real s;
        s = v * (2.0 ** frac);
        if (s >= 0.0) return $rtoi(s + 0.5);
        return -$rtoi(0.5 - s);
    endfunction

    function automatic int step_coef(input lift_step_e step, input int frac);
        real r;
        case (step)
            STEP_PRED1: r = 1.0 / LIFT_ALPHA;
            STEP_UPD1:  r = 1.0 / (LIFT_ALPHA * LIFT_BETA);
            STEP_PRED2: r = 1.0 / (LIFT_BETA * LIFT_GAMMA);
            default:    r = 1.0 / (LIFT_GAMMA * LIFT_DELTA);
        endcase
        return to_fixed(r, frac);
    endfunction

endpackage

// File: rtl/lift97_cell.sv
module lift97_cell #(
    parameter int ACC_W  = 26,
    parameter int COEF_W = 20,
    parameter int FRAC_W = 12,
    parameter int COEF   = 0
) (
    input  logic signed [ACC_W-1:0] mul_i,
    input  logic signed [ACC_W-1:0] add_a_i,
    input  logic signed [ACC_W-1:0] add_b_i,
    output logic signed [ACC_W-1:0] sum_o
);
    localparam int PW = ACC_W + COEF_W;
    localparam logic signed [COEF_W-1:0] K    = COEF_W'(COEF);
    localparam logic signed [PW-1:0]     HALF = PW'(1) <<< (FRAC_W - 1);

    logic signed [PW-1:0]    prod;
    logic signed [PW-1:0]    prod_rnd;
    logic signed [ACC_W:0]   pair;
    logic signed [PW-1:0]    total;

    // the pair sum runs beside the multiplier; only the last add follows it
    always_comb begin
        prod     = PW'(mul_i) * PW'(K);
        prod_rnd = (prod + HALF) >>> FRAC_W;
        pair     = (ACC_W+1)'(add_a_i) + (ACC_W+1)'(add_b_i);
        total    = prod_rnd + PW'(pair);
        sum_o    = total[ACC_W-1:0];
    end

    always_comb begin
        if (!$isunknown(total)) begin
            assert_no_overflow_R7: assert (total == PW'(sum_o))
                else $error("cell result does not fit the accumulator width");
        end
    end

endmodule

// File: rtl/lift97_pipe.sv
module lift97_pipe
    import lift97_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 26,
    parameter int COEF_W = 20,
    parameter int FRAC_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid_i,
    input  logic signed [DATA_W-1:0] x0_i,
    input  logic signed [DATA_W-1:0] x1_i,
    input  logic signed [DATA_W-1:0] x2_i,
    input  logic signed [ACC_W-1:0] pa_i,
    input  logic signed [ACC_W-1:0] pb_i,
    input  logic signed [ACC_W-1:0] pg_i,
    output logic signed [ACC_W-1:0] pa_o,
    output logic signed [ACC_W-1:0] pb_o,
    output logic signed [ACC_W-1:0] pg_o,
    output logic signed [ACC_W-1:0] lo_o,
    output logic signed [ACC_W-1:0] hi_o,
    output logic                    out_valid_o
);
    localparam int K1 = step_coef(STEP_PRED1, FRAC_W);
    localparam int K2 = step_coef(STEP_UPD1,  FRAC_W);
    localparam int K3 = step_coef(STEP_PRED2, FRAC_W);
    localparam int K4 = step_coef(STEP_UPD2,  FRAC_W);

    typedef struct packed {
        logic                    v1;
        logic                    v2;
        logic                    v3;
        logic                    v4;
        logic signed [ACC_W-1:0] a1;
        logic signed [ACC_W-1:0] x0_1;
        logic signed [ACC_W-1:0] b2;
        logic signed [ACC_W-1:0] pa2;
        logic signed [ACC_W-1:0] c3;
        logic signed [ACC_W-1:0] pb3;
        logic signed [ACC_W-1:0] e4;
        logic signed [ACC_W-1:0] c4;
    } pipe_st_t;

    pipe_st_t st_d, st_q;

    logic signed [ACC_W-1:0] x0_ext, x1_ext, x2_ext;
    logic signed [ACC_W-1:0] cell1_y, cell2_y, cell3_y, cell4_y;

    assign x0_ext = ACC_W'(x0_i);
    assign x1_ext = ACC_W'(x1_i);
    assign x2_ext = ACC_W'(x2_i);

    // first prediction: odd sample scaled, even neighbours added
    lift97_cell #(.ACC_W(ACC_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .COEF(K1)) cell1_i (
        .mul_i(x1_ext), .add_a_i(x0_ext), .add_b_i(x2_ext), .sum_o(cell1_y));

    // first update: own and left neighbour's prediction added
    lift97_cell #(.ACC_W(ACC_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .COEF(K2)) cell2_i (
        .mul_i(st_q.x0_1), .add_a_i(pa_i), .add_b_i(st_q.a1), .sum_o(cell2_y));

    // second prediction, one column to the left
    lift97_cell #(.ACC_W(ACC_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .COEF(K3)) cell3_i (
        .mul_i(st_q.pa2), .add_a_i(pb_i), .add_b_i(st_q.b2), .sum_o(cell3_y));

    // second update
    lift97_cell #(.ACC_W(ACC_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .COEF(K4)) cell4_i (
        .mul_i(st_q.pb3), .add_a_i(pg_i), .add_b_i(st_q.c3), .sum_o(cell4_y));

    always_comb begin
        st_d    = st_q;
        st_d.v1 = in_valid_i;
        st_d.v2 = st_q.v1;
        st_d.v3 = st_q.v2;
        st_d.v4 = st_q.v3;
        if (in_valid_i) begin
            st_d.a1   = cell1_y;
            st_d.x0_1 = x0_ext;
        end
        if (st_q.v1) begin
            st_d.b2  = cell2_y;
            st_d.pa2 = pa_i;
        end
        if (st_q.v2) begin
            st_d.c3  = cell3_y;
            st_d.pb3 = pb_i;
        end
        if (st_q.v3) begin
            st_d.e4 = cell4_y;
            st_d.c4 = st_q.c3;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pa_o        = st_q.a1;
    assign pb_o        = st_q.b2;
    assign pg_o        = st_q.c3;
    assign lo_o        = st_q.e4;
    assign hi_o        = st_q.c4;
    assign out_valid_o = st_q.v4;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid_o && lo_o == '0 && hi_o == '0 && pa_o == '0))
        else $error("outputs not cleared by reset");

    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |-> ##4 out_valid_o)
        else $error("accepted window did not emerge after four cycles");

    assert_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |-> ##4 !out_valid_o)
        else $error("valid raised for an idle cycle");

    assert_idle_hold_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> $stable(pa_o))
        else $error("first stage changed while idle");

    assert_idle_hold_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.v1 |=> $stable(pb_o))
        else $error("second stage changed while idle");

    assert_idle_hold_lh_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.v3 |=> ($stable(lo_o) && $stable(hi_o)))
        else $error("output stage changed while idle");

endmodule

// File: rtl/lift97_row.sv
module lift97_row
    import lift97_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int DATA_W = 16,
    parameter int ACC_W  = 26,
    parameter int COEF_W = 20,
    parameter int FRAC_W = 12
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid_i,
    input  logic [(2*LANES+1)*DATA_W-1:0]   samp_i,
    input  logic [ACC_W-1:0]                pa_i,
    input  logic [ACC_W-1:0]                pb_i,
    input  logic [ACC_W-1:0]                pg_i,
    output logic [ACC_W-1:0]                pa_o,
    output logic [ACC_W-1:0]                pb_o,
    output logic [ACC_W-1:0]                pg_o,
    output logic [LANES*ACC_W-1:0]          lo_o,
    output logic [LANES*ACC_W-1:0]          hi_o,
    output logic                            out_valid_o
);
    localparam int NSAMP = 2 * LANES + 1;

    logic signed [ACC_W-1:0] chain_pa [0:LANES];
    logic signed [ACC_W-1:0] chain_pb [0:LANES];
    logic signed [ACC_W-1:0] chain_pg [0:LANES];
    logic [LANES-1:0]        lane_v;

    assign chain_pa[0] = pa_i;
    assign chain_pb[0] = pb_i;
    assign chain_pg[0] = pg_i;

    for (genvar s = 0; s < LANES; s++) begin : g_lane
        logic signed [ACC_W-1:0] lo_s, hi_s;

        lift97_pipe #(
            .DATA_W(DATA_W), .ACC_W(ACC_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)
        ) pipe_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_valid_i (in_valid_i),
            .x0_i       (samp_i[(2*s)  *DATA_W +: DATA_W]),
            .x1_i       (samp_i[(2*s+1)*DATA_W +: DATA_W]),
            .x2_i       (samp_i[(2*s+2)*DATA_W +: DATA_W]),
            .pa_i       (chain_pa[s]),
            .pb_i       (chain_pb[s]),
            .pg_i       (chain_pg[s]),
            .pa_o       (chain_pa[s+1]),
            .pb_o       (chain_pb[s+1]),
            .pg_o       (chain_pg[s+1]),
            .lo_o       (lo_s),
            .hi_o       (hi_s),
            .out_valid_o(lane_v[s])
        );

        assign lo_o[s*ACC_W +: ACC_W] = lo_s;
        assign hi_o[s*ACC_W +: ACC_W] = hi_s;
    end

    assign pa_o        = chain_pa[LANES];
    assign pb_o        = chain_pb[LANES];
    assign pg_o        = chain_pg[LANES];
    assign out_valid_o = lane_v[0];

    initial begin
        assert_window_R2: assert (NSAMP == 2 * LANES + 1 && LANES >= 1)
            else $error("lane count must be at least one");
    end

    assert_lanes_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(lane_v) == 0) || (&lane_v))
        else $error("lanes disagree on result timing");

endmodule

// File: tb/lift97_row_tb.sv
module lift97_row_tb_top;
    localparam int LANES  = 2;
    localparam int DATA_W = 16;
    localparam int ACC_W  = 26;
    localparam int COEF_W = 20;
    localparam int FRAC_W = 12;
    localparam int NSAMP  = 2 * LANES + 1;
    localparam int NSLOT  = 500;
    localparam int PA_LIM = (1 << 17) - 1;
    localparam int PB_LIM = (1 << 20) - 1;
    localparam int PG_LIM = (1 << 22) - 1;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid_i;
    logic [NSAMP*DATA_W-1:0] samp_i;
    logic [ACC_W-1:0] pa_i, pb_i, pg_i, pa_o, pb_o, pg_o;
    logic [LANES*ACC_W-1:0] lo_o, hi_o;
    logic out_valid_o;

    always #5 clk = ~clk;

    lift97_row #(.LANES(LANES), .DATA_W(DATA_W), .ACC_W(ACC_W),
                 .COEF_W(COEF_W), .FRAC_W(FRAC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .samp_i(samp_i),
        .pa_i(pa_i), .pb_i(pb_i), .pg_i(pg_i),
        .pa_o(pa_o), .pb_o(pb_o), .pg_o(pg_o),
        .lo_o(lo_o), .hi_o(hi_o), .out_valid_o(out_valid_o));

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // stimulus and expected values per slot
    longint smp   [NSLOT][NSAMP];
    longint pa_s  [NSLOT];
    longint pb_s  [NSLOT];
    longint pg_s  [NSLOT];
    bit     vld   [NSLOT];
    longint ea    [NSLOT][LANES];
    longint eb    [NSLOT][LANES];
    longint ec    [NSLOT][LANES];
    longint ee    [NSLOT][LANES];

    longint k1, k2, k3, k4;

    function automatic longint kfix(input real v);
        real s;
        s = v * (2.0 ** FRAC_W);
        if (s >= 0.0) return longint'($rtoi(s + 0.5));
        return -longint'($rtoi(0.5 - s));
    endfunction

    function automatic longint rmul(input longint v, input longint k);
        return (v * k + (64'sd1 <<< (FRAC_W - 1))) >>> FRAC_W;
    endfunction

    function automatic longint srand(input int lim);
        return longint'($urandom_range(0, 2 * lim)) - longint'(lim);
    endfunction

    function automatic longint sx(input logic [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] t;
        t = v;
        return longint'(t);
    endfunction

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        longint d;
        total++;
        d = act - exp;
        if (d > 1 || d < -1) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compute_slot(input int t);
        longint pa, pb, pg, a, b, c;
        pa = pa_s[t]; pb = pb_s[t]; pg = pg_s[t];
        for (int s = 0; s < LANES; s++) begin
            a = rmul(smp[t][2*s+1], k1) + smp[t][2*s] + smp[t][2*s+2];
            b = rmul(smp[t][2*s], k2) + pa + a;
            c = rmul(pa, k3) + pb + b;
            ea[t][s] = a; eb[t][s] = b; ec[t][s] = c;
            ee[t][s] = rmul(pb, k4) + pg + c;
            pa = a; pb = b; pg = c;
        end
    endtask

    function automatic bit slot_ok(input int t);
        return (t >= 0 && t < NSLOT) ? vld[t] : 1'b0;
    endfunction

    function automatic string base_tag(input int t, input string dflt);
        if (t == 1 || t == 2 || t == 3 || t == 5 || t == 6) return "R7";
        if (t >= 8 && t <= 40) return "R9";
        return dflt;
    endfunction

    // held outputs when a stage sees no accepted window
    longint h_a = 0, h_b = 0, h_c = 0;
    longint h_l [LANES];
    longint h_h [LANES];

    task automatic drive(input int t);
        in_valid_i = slot_ok(t);
        for (int k = 0; k < NSAMP; k++) begin
            if (slot_ok(t)) samp_i[k*DATA_W +: DATA_W] = DATA_W'(smp[t][k]);
            else            samp_i[k*DATA_W +: DATA_W] = DATA_W'($urandom);
        end
        pa_i = slot_ok(t-1) ? ACC_W'(pa_s[t-1]) : ACC_W'(srand(PA_LIM));
        pb_i = slot_ok(t-2) ? ACC_W'(pb_s[t-2]) : ACC_W'(srand(PB_LIM));
        pg_i = slot_ok(t-3) ? ACC_W'(pg_s[t-3]) : ACC_W'(srand(PG_LIM));
    endtask

    task automatic check_cycle(input int t);
        string tg;
        // stage one: slot t
        if (slot_ok(t)) begin h_a = ea[t][LANES-1]; tg = base_tag(t, "R2"); end
        else tg = "R8";
        chk(tg, "pa_o", sx(pa_o), h_a);
        // stage two: slot t-1
        if (slot_ok(t-1)) begin h_b = eb[t-1][LANES-1]; tg = base_tag(t-1, "R3"); end
        else tg = "R8";
        chk(tg, "pb_o", sx(pb_o), h_b);
        // stage three: slot t-2
        if (slot_ok(t-2)) begin h_c = ec[t-2][LANES-1]; tg = base_tag(t-2, "R4"); end
        else tg = "R8";
        chk(tg, "pg_o", sx(pg_o), h_c);
        // outputs: slot t-3
        tg = slot_ok(t-3) ? base_tag(t-3, "R5") : "R8";
        chk(tg, "out_valid_o", longint'(out_valid_o), longint'(slot_ok(t-3)));
        for (int s = 0; s < LANES; s++) begin
            if (slot_ok(t-3)) begin
                h_l[s] = ee[t-3][s];
                h_h[s] = ec[t-3][s];
                tg = (s > 0) ? "R6" : base_tag(t-3, "R5");
            end else tg = "R8";
            chk(tg, $sformatf("lo_o lane %0d", s), sx(lo_o[s*ACC_W +: ACC_W]), h_l[s]);
            chk(tg, $sformatf("hi_o lane %0d", s), sx(hi_o[s*ACC_W +: ACC_W]), h_h[s]);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0000_5eed));
        k1 = kfix(1.0 / (-1.586134342));
        k2 = kfix(1.0 / ((-1.586134342) * (-0.052980118)));
        k3 = kfix(1.0 / ((-0.052980118) * 0.882911075));
        k4 = kfix(1.0 / (0.882911075 * 0.443506852));
        for (int s = 0; s < LANES; s++) begin h_l[s] = 0; h_h[s] = 0; end

        // directed slots
        for (int t = 0; t < 8; t++) begin
            vld[t] = 1'b1;
            pa_s[t] = 0; pb_s[t] = 0; pg_s[t] = 0;
            for (int k = 0; k < NSAMP; k++) begin
                case (t)
                    0: smp[t][k] = 0;
                    1, 5: smp[t][k] = 32767;
                    2, 6: smp[t][k] = -32768;
                    3: smp[t][k] = (k % 2 == 0) ? 32767 : -32768;
                    default: smp[t][k] = 0;
                endcase
            end
        end
        vld[4] = 1'b0; vld[7] = 1'b0;
        pa_s[5] = PA_LIM;  pb_s[5] = PB_LIM;  pg_s[5] = PG_LIM;
        pa_s[6] = -PA_LIM; pb_s[6] = -PB_LIM; pg_s[6] = -PG_LIM;
        // random slots: a back-to-back run, then gaps
        for (int t = 8; t < NSLOT; t++) begin
            vld[t] = (t <= 40) ? 1'b1 : ($urandom_range(0, 3) != 0);
            for (int k = 0; k < NSAMP; k++) smp[t][k] = srand(32767);
            pa_s[t] = srand(PA_LIM);
            pb_s[t] = srand(PB_LIM);
            pg_s[t] = srand(PG_LIM);
        end
        for (int t = 0; t < NSLOT; t++) compute_slot(t);

        // reset
        rst_n = 1'b0;
        in_valid_i = 1'b0; samp_i = '0; pa_i = '0; pb_i = '0; pg_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "out_valid_o in reset", longint'(out_valid_o), 0);
        chk("R1", "lo_o in reset", sx(lo_o[ACC_W-1:0]), 0);
        rst_n = 1'b1;
        chk("R1", "hi_o after reset", sx(hi_o[ACC_W-1:0]), 0);
        chk("R1", "pa_o after reset", sx(pa_o), 0);
        chk("R1", "pg_o after reset", sx(pg_o), 0);

        for (int t = 0; t < NSLOT + 4; t++) begin
            drive(t);
            @(negedge clk);
            check_cycle(t);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule